// File: doc/BRIEF.md
# Buffered Serial Transceiver

This block is an asynchronous serial transceiver with one start bit, eight data bits and one stop bit, and no parity. It connects a pair of serial lines to a pair of byte queues held elsewhere in the FPGA. The transmit side accepts a byte from a direct load strobe, or fetches one by itself from the outgoing queue whenever that queue holds data and the transmitter is free. It frames the byte on the serial output and reports busy until the stop bit has been sent.

The receive side synchronizes the incoming line and waits for a falling edge. It confirms the start bit at its middle, collects eight data bits least significant bit first and then checks the stop bit. A good frame presents the byte with a one-cycle valid strobe and pushes it into the incoming queue if that queue has room. A frame whose stop bit reads low produces a framing-error strobe instead. A byte that finds the incoming queue full is dropped, and a sticky overrun flag records the loss.

All timing comes from an internal divider. An oversampling tick runs at 16 times the bit rate and drives the receiver. Every sixteenth oversampling tick is a bit tick, which paces the transmitter.

Top module: `uart_buffered_xcvr`

## Requirements
- R1: While rst_ni is low, tx_o is 1 and tx_busy_o, rx_valid_o, rx_frame_err_o, rx_buf_wr_o and rx_overrun_o are 0. tx_buf_rd_o is also 0 when tx_buf_empty_i is 1.
- R2: A tx_load_i pulse while the transmitter is idle latches tx_data_i and sends one frame on tx_o. The frame is a 0 start bit, then the eight data bits with bit 0 first, then a 1 stop bit. Each bit lasts OVERSAMPLE*OS_DIV clock cycles (64 with default parameters). tx_o is 1 whenever no frame is being sent.
- R3: tx_busy_o is 1 from the cycle after an accepted load until the stop bit has finished. A load that arrives while tx_busy_o is 1 is ignored: the frame in flight is unchanged and no further frame follows.
- R4: When tx_buf_empty_i is 0, tx_busy_o is 0 and tx_load_i is 0, tx_buf_rd_o is 1 for one cycle. The byte on tx_buf_data_i is then sent as in R2.
- R5: The receiver starts only on a falling edge of the synchronized rx_i. It confirms the start bit half a bit later. A low pulse shorter than half a bit is discarded without any valid or error strobe, and the receiver then accepts the next frame.
- R6: After a confirmed start bit the receiver samples eight data bits, bit 0 first, at mid-bit. If the stop bit reads 1, rx_data_o holds the byte and rx_valid_o is 1 for exactly one cycle.
- R7: If the stop bit reads 0, rx_frame_err_o is 1 for one cycle and rx_valid_o stays 0. The receiver waits for the line to return high and then accepts the next frame.
- R8: rx_buf_wr_o is 1 in the same cycle as rx_valid_o when rx_buf_full_i is 0. When rx_buf_full_i is 1, no write occurs and rx_overrun_o becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | 8 | Byte for a direct load |
| tx_load_i | input | 1 | Direct load strobe |
| tx_busy_o | output | 1 | Transmitter is sending a frame |
| tx_o | output | 1 | Serial transmit line, idle high |
| tx_buf_data_i | input | 8 | Head byte of the outgoing queue |
| tx_buf_empty_i | input | 1 | Outgoing queue is empty |
| tx_buf_rd_o | output | 1 | Pop strobe for the outgoing queue |
| rx_i | input | 1 | Serial receive line, idle high |
| rx_data_o | output | 8 | Last byte received |
| rx_valid_o | output | 1 | One-cycle strobe for a good frame |
| rx_frame_err_o | output | 1 | One-cycle strobe for a low stop bit |
| rx_buf_full_i | input | 1 | Incoming queue is full |
| rx_buf_wr_o | output | 1 | Push strobe for the incoming queue |
| rx_overrun_o | output | 1 | Sticky flag for a byte dropped on a full queue |

## Verification
The hardest case to reach from the ports is a second load that arrives in the middle of a frame. The bench samples the outgoing frame bit by bit and, just after the fourth data bit, pulses tx_load_i with the inverted byte. It then checks the rest of the frame and confirms that the line stays high and tx_busy_o stays low for several bit times afterwards. The start-glitch filter and the overrun path also need precise timing on the serial input. The bench drives a low pulse shorter than half a bit, and it holds rx_buf_full_i high across a complete good frame so that the valid strobe lands on a full queue.

// File: rtl/uart_pkg.sv
package uart_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_LOAD, TX_DATA, TX_STOP} tx_state_e;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_ERR} rx_state_e;
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int OS_DIV     = 4,
  parameter int OVERSAMPLE = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic os_tick_o,
  output logic bit_tick_o
);
  localparam int DIV_W  = (OS_DIV > 1) ? $clog2(OS_DIV) : 1;
  localparam int SUB_W  = $clog2(OVERSAMPLE);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(OS_DIV - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);

  logic [DIV_W-1:0] div_q;
  logic [SUB_W-1:0] sub_q;

  assign os_tick_o  = (div_q == DIV_LAST);
  assign bit_tick_o = os_tick_o && (sub_q == SUB_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      sub_q <= '0;
    end else begin
      div_q <= os_tick_o ? '0 : div_q + DIV_W'(1);
      if (os_tick_o) sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + SUB_W'(1);
    end
  end

  AST_BIT_TICK_ON_OS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> $past(sub_q) == SUB_W'(OVERSAMPLE - 2) || OVERSAMPLE == 1 || $past(div_q) != DIV_LAST); // R2
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              tx_o
);
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] FRAME_BITS = CNT_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  tx_state_e         state_q;
  logic [DATA_W:0]   shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              tx_q;

  assign busy_o = (state_q != TX_IDLE);
  assign tx_o   = tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      shreg_q <= '1;
      cnt_q   <= '0;
      tx_q    <= 1'b1;
    end else begin
      case (state_q)
        TX_IDLE: if (load_i) begin
          shreg_q <= {data_i, 1'b0};  // start bit in position 0
          cnt_q   <= FRAME_BITS;
          state_q <= TX_LOAD;
        end
        TX_LOAD: if (tick_i) begin
          tx_q    <= shreg_q[0];
          state_q <= TX_DATA;
        end
        TX_DATA: if (tick_i) begin
          tx_q    <= shreg_q[1];  // ones fill in behind: last shift yields stop level
          shreg_q <= {1'b1, shreg_q[DATA_W:1]};
          cnt_q   <= cnt_q - ONE;
          if (cnt_q == ONE) state_q <= TX_STOP;
        end
        TX_STOP: if (tick_i) state_q <= TX_IDLE;
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_IDLE) |-> tx_q); // R2
  AST_LOAD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && load_i && !tick_i) |=> $stable(shreg_q) && $stable(cnt_q)); // R3
  AST_STOP_IS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_STOP) |-> tx_q); // R2
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              os_tick_i,
  input  logic              rx_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              frame_err_o
);
  localparam int TICK_W = $clog2(OVERSAMPLE);
  localparam int BIT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [TICK_W-1:0] HALF_LAST = TICK_W'(OVERSAMPLE / 2 - 1);
  localparam logic [TICK_W-1:0] FULL_LAST = TICK_W'(OVERSAMPLE - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic              sync1_q, sync2_q, prev_q;
  logic              fall;
  logic [TICK_W-1:0] tick_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] shreg_q;
  logic              valid_q, ferr_q;

  assign fall        = prev_q && !sync2_q;
  assign valid_o     = valid_q;
  assign frame_err_o = ferr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      prev_q  <= 1'b1;
    end else begin
      sync1_q <= rx_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      tick_q  <= '0;
      bit_q   <= '0;
      shreg_q <= '0;
      data_o  <= '0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
      case (state_q)
        RX_IDLE: if (fall) begin
          tick_q  <= '0;
          state_q <= RX_START;
        end
        RX_START: if (os_tick_i) begin
          if (tick_q == HALF_LAST) begin
            tick_q  <= '0;
            bit_q   <= '0;
            state_q <= sync2_q ? RX_IDLE : RX_DATA;  // high at mid-bit: glitch
          end else tick_q <= tick_q + TICK_W'(1);
        end
        RX_DATA: if (os_tick_i) begin
          if (tick_q == FULL_LAST) begin
            tick_q  <= '0;
            shreg_q <= {sync2_q, shreg_q[DATA_W-1:1]};
            bit_q   <= bit_q + BIT_W'(1);
            if (bit_q == BIT_LAST) state_q <= RX_STOP;
          end else tick_q <= tick_q + TICK_W'(1);
        end
        RX_STOP: if (os_tick_i) begin
          if (tick_q == FULL_LAST) begin
            tick_q <= '0;
            if (sync2_q) begin
              data_o  <= shreg_q;
              valid_q <= 1'b1;
              state_q <= RX_IDLE;
            end else begin
              ferr_q  <= 1'b1;
              state_q <= RX_ERR;
            end
          end else tick_q <= tick_q + TICK_W'(1);
        end
        RX_ERR: if (sync2_q) state_q <= RX_IDLE;
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  AST_START_FROM_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_START && $past(state_q) == RX_IDLE) |-> $past(fall)); // R5
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q); // R6
  AST_ERR_NOT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ferr_q |-> !valid_q && state_q == RX_ERR); // R7
  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> $stable(data_o)); // R6
endmodule

// File: rtl/uart_buffered_xcvr.sv
module uart_buffered_xcvr #(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16,
  parameter int OS_DIV     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_load_i,
  output logic              tx_busy_o,
  output logic              tx_o,
  input  logic [DATA_W-1:0] tx_buf_data_i,
  input  logic              tx_buf_empty_i,
  output logic              tx_buf_rd_o,
  input  logic              rx_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_frame_err_o,
  input  logic              rx_buf_full_i,
  output logic              rx_buf_wr_o,
  output logic              rx_overrun_o
);
  logic              os_tick, bit_tick;
  logic              tx_ld;
  logic [DATA_W-1:0] tx_din;
  logic              overrun_q;

  uart_baud_gen #(.OS_DIV(OS_DIV), .OVERSAMPLE(OVERSAMPLE)) u_baud (
    .clk_i, .rst_ni, .os_tick_o(os_tick), .bit_tick_o(bit_tick)
  );

  // direct load wins; queue is drained only when nothing else asks
  assign tx_buf_rd_o = !tx_buf_empty_i && !tx_busy_o && !tx_load_i;
  assign tx_ld       = tx_load_i || tx_buf_rd_o;
  assign tx_din      = tx_load_i ? tx_data_i : tx_buf_data_i;

  uart_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i, .rst_ni, .tick_i(bit_tick), .load_i(tx_ld), .data_i(tx_din),
    .busy_o(tx_busy_o), .tx_o
  );

  uart_rx #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_rx (
    .clk_i, .rst_ni, .os_tick_i(os_tick), .rx_i, .data_o(rx_data_o),
    .valid_o(rx_valid_o), .frame_err_o(rx_frame_err_o)
  );

  assign rx_buf_wr_o  = rx_valid_o && !rx_buf_full_i;
  assign rx_overrun_o = overrun_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          overrun_q <= 1'b0;
    else if (rx_valid_o && rx_buf_full_i) overrun_q <= 1'b1;
  end

  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_buf_full_i |-> !rx_buf_wr_o); // R8
  AST_OVERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_q |=> overrun_q); // R8
  AST_FETCH_STARTS_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_buf_rd_o |=> tx_busy_o); // R4
endmodule

// File: tb/sim_uart_buffered_xcvr.sv
`timescale 1ns/1ps
module sim_uart_buffered_xcvr;
  localparam int BIT_CYC = 64;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] tx_data_i = '0;
  logic tx_load_i = 1'b0;
  logic tx_busy_o, tx_o;
  logic [7:0] tx_buf_data_i = '0;
  logic tx_buf_empty_i = 1'b1;
  logic tx_buf_rd_o;
  logic rx_i = 1'b1;
  logic [7:0] rx_data_o;
  logic rx_valid_o, rx_frame_err_o;
  logic rx_buf_full_i = 1'b0;
  logic rx_buf_wr_o, rx_overrun_o;

  int checks = 0, errors = 0;
  int n_valid = 0, n_wr = 0, n_ferr = 0, n_rd = 0;
  logic [7:0] last_rx = '0;

  always #2.5 clk_i = ~clk_i;

  uart_buffered_xcvr u0 (.*);

  always @(negedge clk_i) if (rst_ni) begin
    if (rx_valid_o) begin n_valid++; last_rx = rx_data_o; end
    if (rx_buf_wr_o) n_wr++;
    if (rx_frame_err_o) n_ferr++;
    if (tx_buf_rd_o) n_rd++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  // capture a frame on tx_o; optionally inject a load after bit 3
  task automatic grab_tx(input logic [7:0] exp, input bit inject, input string req);
    int t = 0;
    logic [7:0] got = '0;
    do begin @(negedge clk_i); t++; end while (tx_o && t < 2000);
    chk(t < 2000, req, t, 0);
    repeat (BIT_CYC/2) @(negedge clk_i);
    chk(tx_o == 1'b0, {req, " start"}, tx_o, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (BIT_CYC) @(negedge clk_i);
      got[i] = tx_o;
      if (inject && i == 3) begin
        #1; tx_load_i = 1'b1; tx_data_i = ~exp;
        @(posedge clk_i); #1; tx_load_i = 1'b0;
      end
    end
    chk(got == exp, {req, " data"}, got, exp);
    repeat (BIT_CYC) @(negedge clk_i);
    chk(tx_o == 1'b1 && tx_busy_o, {req, " stop/busy"}, {tx_o, tx_busy_o}, 2'b11);
  endtask

  task automatic t_tx_direct(input logic [7:0] d, input bit inject);
    step(); tx_data_i = d; tx_load_i = 1'b1;
    step(); tx_load_i = 1'b0;
    @(negedge clk_i);
    chk(tx_busy_o, "R3 busy after load", tx_busy_o, 1);
    grab_tx(d, inject, inject ? "R3 frame with late load" : "R2 frame");
    repeat (BIT_CYC) @(negedge clk_i);
    chk(!tx_busy_o, "R3 busy drops", tx_busy_o, 0);
    if (inject) begin
      int lows = 0;
      repeat (4*BIT_CYC) begin @(negedge clk_i); if (!tx_o || tx_busy_o) lows++; end
      chk(lows == 0, "R3 ignored load sent nothing", lows, 0);
    end
  endtask

  task automatic t_tx_buffer(input logic [7:0] d);
    int rd0 = n_rd;
    step(); tx_buf_data_i = d; tx_buf_empty_i = 1'b0;
    step(); tx_buf_empty_i = 1'b1; tx_buf_data_i = 8'h00;
    @(negedge clk_i);
    chk(n_rd - rd0 == 1, "R4 single pop", n_rd - rd0, 1);
    grab_tx(d, 1'b0, "R4 queued frame");
    repeat (BIT_CYC + 4) @(negedge clk_i);
    chk(n_rd - rd0 == 1 && !tx_busy_o, "R4 no extra pop", n_rd - rd0, 1);
  endtask

  task automatic send_rx(input logic [7:0] d, input logic stop);
    logic [9:0] f = {stop, d, 1'b0};
    for (int i = 0; i < 10; i++) begin
      step(); rx_i = f[i];
      repeat (BIT_CYC - 1) @(posedge clk_i);
    end
    step(); rx_i = 1'b1;
    repeat (8) @(negedge clk_i);
  endtask

  task automatic t_rx_good(input logic [7:0] d);
    int v0 = n_valid, w0 = n_wr, e0 = n_ferr;
    send_rx(d, 1'b1);
    chk(n_valid - v0 == 1, "R6 one valid strobe", n_valid - v0, 1);
    chk(last_rx == d && rx_data_o == d, "R6 data", last_rx, d);
    chk(n_wr - w0 == 1 && n_ferr == e0, "R8 write on room", n_wr - w0, 1);
  endtask

  task automatic t_rx_glitch();
    int v0 = n_valid, e0 = n_ferr;
    step(); rx_i = 1'b0;
    repeat (12) @(posedge clk_i);
    #1; rx_i = 1'b1;
    repeat (3*BIT_CYC) @(negedge clk_i);
    chk(n_valid == v0 && n_ferr == e0, "R5 glitch discarded", n_valid - v0, 0);
    t_rx_good(8'hC3);
  endtask

  task automatic t_rx_framing();
    int v0 = n_valid, e0 = n_ferr;
    send_rx(8'hA5, 1'b0);
    repeat (BIT_CYC) @(negedge clk_i);
    chk(n_ferr - e0 == 1, "R7 framing strobe", n_ferr - e0, 1);
    chk(n_valid == v0, "R7 no valid", n_valid - v0, 0);
    t_rx_good(8'h3E);
  endtask

  task automatic t_overrun();
    int v0 = n_valid, w0 = n_wr;
    step(); rx_buf_full_i = 1'b1;
    send_rx(8'h77, 1'b1);
    chk(n_valid - v0 == 1 && n_wr == w0, "R8 no write when full", n_wr - w0, 0);
    chk(rx_overrun_o, "R8 overrun set", rx_overrun_o, 1);
    step(); rx_buf_full_i = 1'b0;
    t_rx_good(8'h19);
    chk(rx_overrun_o, "R8 overrun sticky", rx_overrun_o, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk_i);
    chk(tx_o && !tx_busy_o && !tx_buf_rd_o, "R1 tx reset", {tx_o, tx_busy_o, tx_buf_rd_o}, 3'b100);
    chk(!rx_valid_o && !rx_frame_err_o && !rx_buf_wr_o && !rx_overrun_o, "R1 rx reset",
        {rx_valid_o, rx_frame_err_o, rx_buf_wr_o, rx_overrun_o}, 0);
    step(); rst_ni = 1'b1;
    repeat (10) step();
    t_tx_direct(8'hA5, 1'b0);
    t_tx_direct(8'h01, 1'b1);
    t_tx_buffer(8'h3C);
    t_rx_good(8'h5A);
    t_rx_good(8'h80);
    t_rx_glitch();
    t_rx_framing();
    t_overrun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule